// File: doc/BRIEF.md
# Dual-Edge Pixel Input Capture

This block takes parallel pixel data and the three timing signals (data enable, horizontal sync and vertical sync) from a source-synchronous video port. It delivers one 24-bit pixel word per reference-clock cycle, with its timing signals aligned to it, in the rising-edge domain of that clock. The port can be wide, with all 24 bits arriving on one clock edge. It can also be narrow, with 12 bits on each of two successive edges that are joined into one word. Either the rising or the falling edge of the clock can be the primary edge, the one that opens each pixel.

Two sources can supply the mode and the primary edge. One is a pair of static strap inputs. The other is a small internal register pair written through a simple write strobe. A select input chooses the source. While that select is low, the register pair is held at its defaults, so taking the select low and then high again discards any earlier register writes. When the resolved configuration changes, the words that straddle the change are marked invalid rather than being built from mixed samples.

Top module: `pixel_capture`

## Requirements
- R1: While `rst_n` is low, `pix_data`, `pix_de`, `pix_hs`, `pix_vs` and `pix_valid` are all 0. After release, the first word with `pix_valid` high appears on the third rising edge with `rst_n` high.
- R2: Wide mode with rising primary edge: `pix_data` equals the `in_data` sampled on a rising edge, and it is updated on the second rising edge after that one.
- R3: Wide mode with falling primary edge: `pix_data` equals the `in_data` sampled on a falling edge, and it is updated on the second rising edge after that falling edge.
- R4: Narrow mode: `pix_data[11:0]` is `in_data[11:0]` from the primary edge, and `pix_data[23:12]` is `in_data[11:0]` from the next edge of the opposite polarity. `in_data[23:12]` has no effect in this mode.
- R5: `pix_de`, `pix_hs` and `pix_vs` are the values of `in_de`, `in_hs` and `in_vs` on the primary edge of the same word, in both modes.
- R6: Encoding of the configuration: a mode bit of 1 selects wide mode and 0 selects narrow mode; an edge bit of 1 makes the rising edge primary and 0 makes the falling edge primary.
- R7: With `cfg_src_reg` low, `strap_wide` and `strap_rise` set the configuration. With it high, the register pair sets it, and the strap inputs have no effect.
- R8: The register pair defaults to wide mode with a rising primary edge. A rising edge with `reg_wr` and `cfg_src_reg` both high loads `reg_wide` and `reg_rise` into it, and the new values take effect from the following rising edge.
- R9: `cfg_src_reg` low asynchronously returns the register pair to its defaults, so values written earlier are lost.
- R10: On the first rising edge at which the resolved configuration differs from its value on the previous edge, `pix_valid` goes low, and it stays low for that word and the next one.
- R11: Outside the cases of R1 and R10, `pix_valid` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the video port; both of its edges sample the inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 24 | Pixel data bus (only bits 11:0 are used in narrow mode) |
| in_de | input | 1 | Data enable from the source |
| in_hs | input | 1 | Horizontal sync from the source |
| in_vs | input | 1 | Vertical sync from the source |
| strap_wide | input | 1 | Strapped mode bit: 1 wide, 0 narrow |
| strap_rise | input | 1 | Strapped edge bit: 1 rising primary, 0 falling primary |
| cfg_src_reg | input | 1 | 1 uses the register pair, 0 uses the straps; low clears the register pair |
| reg_wr | input | 1 | Write strobe for the register pair |
| reg_wide | input | 1 | Mode bit to be written |
| reg_rise | input | 1 | Edge bit to be written |
| pix_data | output | 24 | Assembled pixel word |
| pix_de | output | 1 | Data enable aligned with the word |
| pix_hs | output | 1 | Horizontal sync aligned with the word |
| pix_vs | output | 1 | Vertical sync aligned with the word |
| pix_valid | output | 1 | High when the word was built from samples taken under one configuration |

## Verification
Some behaviours are checked on every cycle. These are the invalid window of two words that follows a configuration change, and the hold of the register pair at its defaults while the source select is low. The path from rising-edge samples to the output is also checked on every cycle, with its three-edge delay for wide words and for the low half and timing signals of narrow words. Anything that depends on the falling-edge sample can only be shown by the bench's scenarios, because that sample falls between the rising edges where properties are evaluated. These are the falling-primary words and the upper half of narrow words. The same holds for strap inputs that change without effect in register mode, and for the loss of written values when the select is toggled.

// File: rtl/pixel_capture_pkg.sv
`timescale 1ns/1ps
package pixel_capture_pkg;

  // Resolved capture configuration (R6 encoding).
  typedef struct packed {
    logic wide;  // 1: full word on one edge, 0: half word per edge
    logic rise;  // 1: rising primary edge, 0: falling primary edge
  } cap_cfg_t;

  localparam cap_cfg_t CAP_CFG_DEFAULT = '{wide: 1'b1, rise: 1'b1};

endpackage

// File: rtl/pixel_capture_cfg_regs.sv
`timescale 1ns/1ps
module pixel_capture_cfg_regs
  import pixel_capture_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     src_reg,
  input  logic     wr_en,
  input  cap_cfg_t wr_val,
  output cap_cfg_t cfg_q
);

  // The source select doubles as the register clear (R9).
  logic clr_n;
  assign clr_n = rst_n & src_reg;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      cfg_q <= CAP_CFG_DEFAULT;
    end else if (wr_en) begin
      cfg_q <= wr_val;
    end
  end

  AST_REGS_AT_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !src_reg |-> (cfg_q == CAP_CFG_DEFAULT)); // R9

endmodule

// File: rtl/pixel_capture_sampler.sv
`timescale 1ns/1ps
module pixel_capture_sampler #(
  parameter int SW = 27
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] smp_in,
  output logic [SW-1:0] rise_cur,
  output logic [SW-1:0] rise_prev,
  output logic [SW-1:0] fall_hold
);

  logic [SW-1:0] fall_cur;

  // Falling-edge sample, carried into the rising domain half a cycle later.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_cur <= '0;
    else        fall_cur <= smp_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cur  <= '0;
      rise_prev <= '0;
      fall_hold <= '0;
    end else begin
      rise_cur  <= smp_in;
      rise_prev <= rise_cur;
      fall_hold <= fall_cur;
    end
  end

endmodule

// File: rtl/pixel_capture_builder.sv
`timescale 1ns/1ps
module pixel_capture_builder
  import pixel_capture_pkg::*;
#(
  parameter int HALF_W = 12,
  localparam int W  = 2 * HALF_W,
  localparam int SW = W + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cap_cfg_t      cfg,
  input  logic [SW-1:0] rise_cur,
  input  logic [SW-1:0] rise_prev,
  input  logic [SW-1:0] fall_hold,
  output logic [W-1:0]  pix_data,
  output logic          pix_de,
  output logic          pix_hs,
  output logic          pix_vs,
  output logic          pix_valid,
  output cap_cfg_t      word_cfg
);

  localparam int FILL_MAX = 2;

  // Timing bits from the primary sample; data full or as two low halves.
  function automatic logic [SW-1:0] build_word(input logic wide,
                                               input logic [SW-1:0] pri,
                                               input logic [SW-1:0] sec);
    if (wide) return pri;
    return {pri[SW-1:W], sec[HALF_W-1:0], pri[HALF_W-1:0]};
  endfunction

  logic [SW-1:0] pri_smp;
  logic [SW-1:0] sec_smp;
  logic          cfg_chg;
  logic          settle;
  logic [1:0]    fill;
  logic          warm;
  logic [SW-1:0] word_q;

  // Rising primary: older rising sample + following fall.
  // Falling primary: held fall sample + following rise.
  assign pri_smp = cfg.rise ? rise_prev : fall_hold;
  assign sec_smp = cfg.rise ? fall_hold : rise_cur;
  assign cfg_chg = (cfg != word_cfg);
  assign warm    = (fill == 2'(FILL_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_cfg  <= CAP_CFG_DEFAULT;
      fill      <= '0;
      settle    <= 1'b0;
      word_q    <= '0;
      pix_valid <= 1'b0;
    end else begin
      word_cfg  <= cfg;
      if (!warm) fill <= fill + 2'd1;
      settle    <= cfg_chg;
      word_q    <= build_word(cfg.wide, pri_smp, sec_smp);
      pix_valid <= warm && !cfg_chg && !settle;
    end
  end

  assign pix_data = word_q[W-1:0];
  assign pix_de   = word_q[W];
  assign pix_hs   = word_q[W+1];
  assign pix_vs   = word_q[W+2];

  AST_DROP_AT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !pix_valid); // R10

  AST_DROP_AFTER_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg ##1 1'b1 |=> !pix_valid); // R10

endmodule

// File: rtl/pixel_capture.sv
`timescale 1ns/1ps
module pixel_capture
  import pixel_capture_pkg::*;
#(
  parameter int HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] in_data,
  input  logic                in_de,
  input  logic                in_hs,
  input  logic                in_vs,
  input  logic                strap_wide,
  input  logic                strap_rise,
  input  logic                cfg_src_reg,
  input  logic                reg_wr,
  input  logic                reg_wide,
  input  logic                reg_rise,
  output logic [2*HALF_W-1:0] pix_data,
  output logic                pix_de,
  output logic                pix_hs,
  output logic                pix_vs,
  output logic                pix_valid
);

  localparam int W  = 2 * HALF_W;
  localparam int SW = W + 3;

  cap_cfg_t      reg_cfg;
  cap_cfg_t      use_cfg;
  cap_cfg_t      word_cfg;
  cap_cfg_t      wr_val;
  logic [SW-1:0] smp_in;
  logic [SW-1:0] rise_cur;
  logic [SW-1:0] rise_prev;
  logic [SW-1:0] fall_hold;

  assign wr_val  = '{wide: reg_wide, rise: reg_rise};
  assign use_cfg = cfg_src_reg ? reg_cfg : '{wide: strap_wide, rise: strap_rise};
  assign smp_in  = {in_vs, in_hs, in_de, in_data};

  pixel_capture_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_reg (cfg_src_reg),
    .wr_en   (reg_wr),
    .wr_val  (wr_val),
    .cfg_q   (reg_cfg)
  );

  pixel_capture_sampler #(.SW(SW)) u_smp (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_in    (smp_in),
    .rise_cur  (rise_cur),
    .rise_prev (rise_prev),
    .fall_hold (fall_hold)
  );

  pixel_capture_builder #(.HALF_W(HALF_W)) u_bld (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (use_cfg),
    .rise_cur  (rise_cur),
    .rise_prev (rise_prev),
    .fall_hold (fall_hold),
    .pix_data  (pix_data),
    .pix_de    (pix_de),
    .pix_hs    (pix_hs),
    .pix_vs    (pix_vs),
    .pix_valid (pix_valid),
    .word_cfg  (word_cfg)
  );

  // A valid word seen at this edge was built one edge ago from a rising sample three edges ago.
  AST_WIDE_RISE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && word_cfg.wide && word_cfg.rise)
      |-> (pix_data == $past(in_data, 3))); // R2

  AST_NARROW_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !word_cfg.wide && word_cfg.rise)
      |-> (pix_data[HALF_W-1:0] == $past(in_data[HALF_W-1:0], 3))); // R4

  AST_SYNC_FROM_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && word_cfg.rise)
      |-> ({pix_vs, pix_hs, pix_de} == $past({in_vs, in_hs, in_de}, 3))); // R5

endmodule

// File: tb/pixel_capture_tb_top.sv
`timescale 1ns/1ps
module pixel_capture_tb_top;

  localparam int HALF_W = 12;
  localparam int W      = 2 * HALF_W;
  localparam int SW     = W + 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic         strap_wide = 1'b1, strap_rise = 1'b1;
  logic         cfg_src_reg = 1'b0, reg_wr = 1'b0, reg_wide = 1'b0, reg_rise = 1'b0;
  logic [W-1:0] pix_data;
  logic         pix_de, pix_hs, pix_vs, pix_valid;

  pixel_capture #(.HALF_W(HALF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_de(in_de), .in_hs(in_hs),
    .in_vs(in_vs), .strap_wide(strap_wide), .strap_rise(strap_rise),
    .cfg_src_reg(cfg_src_reg), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_rise(reg_rise), .pix_data(pix_data), .pix_de(pix_de), .pix_hs(pix_hs),
    .pix_vs(pix_vs), .pix_valid(pix_valid)
  );

  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_change = -100;
  int rst_rel = 1 << 30;
  string phase_tag = "";
  logic [SW-1:0] rise_hist [1024];
  logic [SW-1:0] fall_hist [1024];
  logic [1:0]    cfg_at [1024];   // {wide, rise}
  logic [1:0]    mreg = 2'b11;
  logic [1:0]    prev_res = 2'b11;
  logic [1:0]    res;

  function automatic logic [SW-1:0] pat(input int h);
    logic [31:0] x;
    x = h * 32'h9E3779B1 + 32'h01234567;
    x = x ^ (x >> 15);
    x = x * 32'h2C1B3C6D;
    x = x ^ (x >> 12);
    return x[SW-1:0];
  endfunction

  task automatic drive(input logic [SW-1:0] v);
    {in_vs, in_hs, in_de, in_data} = v;
  endtask

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Expected register pair per R8/R9.
  always @(posedge clk or negedge cfg_src_reg or negedge rst_n) begin
    if (!rst_n || !cfg_src_reg) mreg <= 2'b11;
    else if (reg_wr)            mreg <= {reg_wide, reg_rise};
  end

  // Per-edge stimulus and record of the resolved configuration (R7).
  always @(posedge clk) begin
    logic [SW-1:0] v;
    cyc = cyc + 1;
    res = cfg_src_reg ? mreg : {strap_wide, strap_rise};
    if (!rst_n) prev_res = 2'b11;
    else begin
      if (rst_rel > cyc) rst_rel = cyc;
      if (res != prev_res) begin
        last_change = cyc;
        prev_res = res;
      end
    end
    cfg_at[cyc % 1024] = res;
    #2;
    v = pat(2 * cyc + 1);
    fall_hist[cyc % 1024] = v;
    drive(v);
    #5;
    v = pat(2 * cyc + 2);
    rise_hist[(cyc + 1) % 1024] = v;
    drive(v);
  end

  task automatic check_cycle(input int p);
    bit            exp_v;
    string         vtag, mtag;
    logic [1:0]    c;
    logic [SW-1:0] pri, sec;
    logic [W-1:0]  exp_d;
    if (!rst_n) begin
      check(!pix_valid && pix_data == '0 && {pix_vs, pix_hs, pix_de} == 3'b000, "R1",
            {5'b0, pix_vs, pix_hs, pix_de, pix_data}, 32'h0);
      return;
    end
    exp_v = (p >= rst_rel + 2) && (p - last_change >= 2);
    if (p - last_change < 2) vtag = "R10";
    else if (p < rst_rel + 2) vtag = "R1";
    else vtag = "R11";
    check(pix_valid == exp_v, vtag, {31'b0, pix_valid}, {31'b0, exp_v});
    if (!(exp_v && pix_valid)) return;
    c = cfg_at[p % 1024];
    if (c[0]) begin
      pri = rise_hist[(p - 2) % 1024];
      sec = fall_hist[(p - 2) % 1024];
    end else begin
      pri = fall_hist[(p - 2) % 1024];
      sec = rise_hist[(p - 1) % 1024];
    end
    if (c[1]) begin
      exp_d = pri[W-1:0];
      mtag  = c[0] ? "R2" : "R3";
    end else begin
      exp_d = {sec[HALF_W-1:0], pri[HALF_W-1:0]};
      mtag  = "R4";
    end
    check(pix_data == exp_d, $sformatf("%s %s", mtag, phase_tag),
          {8'b0, pix_data}, {8'b0, exp_d});
    check({pix_vs, pix_hs, pix_de} == pri[SW-1:W], $sformatf("R5 %s", phase_tag),
          {29'b0, pix_vs, pix_hs, pix_de}, {29'b0, pri[SW-1:W]});
  endtask

  always @(posedge clk) begin
    #1;
    check_cycle(cyc);
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic write_regs(input logic [1:0] v);
    {reg_wide, reg_rise} = v;
    reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
    step(12);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    // R6: all four strap combinations.
    phase_tag = "R6";
    for (int i = 3; i >= 0; i--) begin
      {strap_wide, strap_rise} = 2'(i);
      step(12);
    end
    // R7: register source with straps set differently, then strap toggles ignored.
    phase_tag = "R7";
    {strap_wide, strap_rise} = 2'b00;
    cfg_src_reg = 1'b1;
    step(12);
    {strap_wide, strap_rise} = 2'b10;
    step(6);
    {strap_wide, strap_rise} = 2'b01;
    step(6);
    // R8: register writes.
    phase_tag = "R8";
    write_regs(2'b00);
    write_regs(2'b10);
    write_regs(2'b01);
    // R9: select low then high clears the written value back to defaults.
    phase_tag = "R9";
    {strap_wide, strap_rise} = 2'b00;
    cfg_src_reg = 1'b0;
    step(8);
    cfg_src_reg = 1'b1;
    step(12);
    phase_tag = "";
    step(4);
    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule